// File: doc/BRIEF.md
# ADC Result-Flag and Interrupt-Vector Controller

This block sits between an analog-to-digital conversion engine and a processor bus. Each conversion result lands in one of a set of result slots. Each slot carries a new-data flag and its own enable bit. The block also watches for two error events. The first is a result that lands on a slot whose previous result was never collected. The second is a conversion request that arrives while the converter is still busy. The two error events keep no flag that software can see.

Every enabled pending source feeds a fixed-priority encoder. Its output is an even-numbered vector register, and software reads that register to find out which source to service first. Reading or writing the vector register clears an error event, but only when that error is the code being returned at that moment. Slot flags are cleared by reading the slot's result, or by loading the flag register directly.

A single-cycle DMA trigger follows each conversion in single-channel operation. In sequence operation it follows only the last conversion of the sequence.

Top module: `adc_irq_ctrl`

## Requirements
- R1: After reset, all slot flags, slot enables, control bits and error events are clear, the vector reads 0, and `irq` and `dma_trig` are low.
- R2: A `res_we` strobe stores `res_data` into slot `res_idx` and sets that slot's flag. A bus read of address n (0..15) returns slot n's stored result.
- R3: A `res_we` strobe to a slot whose flag is already set raises the overwrite error.
- R4: A `conv_req` strobe while `conv_busy` is high raises the conversion-time error. A `conv_req` strobe with `conv_busy` low raises nothing.
- R5: The vector value is the code of the highest-priority enabled pending source. Codes run from highest to lowest priority: overwrite error 2, conversion-time error 4, slot n 6+2n (slot 0 above slot 15), and 0 when nothing is pending. Slot n is enabled by bit n of the enable register (address 17). The overwrite error is enabled by control bit 1 and the conversion-time error by control bit 2 (control at address 18). A disabled source never changes the vector.
- R6: `irq` is high exactly when control bit 0 (global enable) is set and the vector is nonzero.
- R7: Any read or write of the vector register (address 19) clears the overwrite error if the vector being returned is 2, or the conversion-time error if it is 4. Any other error event is left pending.
- R8: An access to the vector register never clears slot flags. A bus read of slot n clears flag n. A bus write to the flag register (address 16) loads the flags from the write data, and a read of that address returns them.
- R9: `dma_trig` pulses for one cycle, one cycle after a `res_we` strobe. This happens when `seq_mode` is low, or when `seq_mode` is high and `seq_last` is high. Otherwise it stays low.
- R10: When a set event and a clear event reach the same flag or error event in the same cycle, it ends up set.
- R11: The vector and `irq` change one clock after the flag or enable change that causes them, which is two clocks after the input strobe.
- R12: After one source is serviced, `irq` stays high while any other enabled source is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_we | input | 1 | Result write strobe |
| res_idx | input | 4 | Slot index for the result |
| res_data | input | 12 | Result value |
| seq_mode | input | 1 | 1 = sequence operation, 0 = single-channel |
| seq_last | input | 1 | Marks the last result of a sequence |
| conv_req | input | 1 | Sample-and-convert request strobe |
| conv_busy | input | 1 | Converter is busy with a conversion |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of the access |
| irq | output | 1 | Interrupt request |
| dma_trig | output | 1 | DMA trigger pulse |

## Verification
Flags, stored results, error events and `dma_trig` are registered on the edge that samples the strobe. The bench therefore checks them at the falling edge after that rising edge. The vector and `irq` trail by one further register, so the bench checks `irq` low one cycle after a result write and high one cycle later. It also places an idle cycle between any clearing access and the next vector read. Bus read data is combinational within the access cycle, and the bench samples it shortly after driving the address on the falling edge.

// File: rtl/adc_irq_pkg.sv
// Shared constants for the ADC interrupt-vector controller: vector codes
// and register map. Assumes a slot count of 16 or fewer, so that the
// register map fits the address space.
package adc_irq_pkg;
    localparam int VEC_NONE = 0;
    localparam int VEC_OVR  = 2;
    localparam int VEC_TOV  = 4;
    localparam int VEC_SLOT = 6;
    localparam int BUS_W    = 16;
endpackage

// File: rtl/adc_err_flag.sv
// One hidden error event: sets on a request and clears on a qualified
// clear request. Set wins over clear. Assumes both inputs are single-cycle.
module adc_err_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    // hold the pending state; a set always beats a clear
    always_ff @(posedge clk) begin
        if (!rst_n) pend_o <= 1'b0;
        else        pend_o <= set_i | (pend_o & ~clr_i);
    end

    AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> pend_o); // R10
endmodule

// File: rtl/adc_slot_bank.sv
// Result slots and their new-data flags. Assumes at most one result write
// and at most one slot read per cycle. A software load replaces all flags,
// but a result write in the same cycle still sets its own flag.
module adc_slot_bank #(
    parameter int SLOTS = 16,
    parameter int DW    = 12,
    localparam int IW   = $clog2(SLOTS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IW-1:0]              wr_idx,
    input  logic [DW-1:0]              wr_data,
    input  logic                       rd_clr,
    input  logic [IW-1:0]              rd_idx,
    input  logic                       sw_ld,
    input  logic [SLOTS-1:0]           sw_val,
    output logic [SLOTS-1:0]           flags,
    output logic [SLOTS-1:0][DW-1:0]   data
);
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic hit_set, hit_clr, base;
        // decode this slot's set and clear events
        always_comb begin
            hit_set = wr_en && (wr_idx == IW'(i));
            hit_clr = rd_clr && (rd_idx == IW'(i));
            base    = sw_ld ? sw_val[i] : (flags[i] & ~hit_clr);
        end
        // update the flag (set wins) and capture result data
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
                data[i]  <= '0;
            end else begin
                flags[i] <= hit_set | base;
                if (hit_set) data[i] <= wr_data;
            end
        end
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> flags[$past(wr_idx)]); // R2
endmodule

// File: rtl/adc_vec_prio.sv
// Fixed-priority encoder over enabled pending sources, registered into the
// vector. Assumes the slot codes fit in the vector width.
module adc_vec_prio #(
    parameter int SLOTS = 16,
    parameter int VW    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SLOTS-1:0] flags,
    input  logic [SLOTS-1:0] slot_en,
    input  logic             ovr_pend,
    input  logic             ovr_en,
    input  logic             tov_pend,
    input  logic             tov_en,
    output logic [VW-1:0]    vec_q
);
    import adc_irq_pkg::*;

    logic [SLOTS-1:0] live;
    logic [VW-1:0]    vec_d;

    // pick the highest-priority enabled source; slot 0 outranks higher slots
    always_comb begin
        live  = flags & slot_en;
        vec_d = VW'(VEC_NONE);
        for (int n = SLOTS - 1; n >= 0; n--) begin
            if (live[n]) vec_d = VW'(VEC_SLOT + 2 * n);
        end
        if (tov_pend && tov_en) vec_d = VW'(VEC_TOV);
        if (ovr_pend && ovr_en) vec_d = VW'(VEC_OVR);
    end

    // register the vector one cycle behind the sources
    always_ff @(posedge clk) begin
        if (!rst_n) vec_q <= '0;
        else        vec_q <= vec_d;
    end

    AST_VEC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & slot_en) == '0 && !(ovr_pend && ovr_en) && !(tov_pend && tov_en))
        |=> vec_q == '0); // R5
    AST_VEC_OVR_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_pend && ovr_en) |=> vec_q == VW'(VEC_OVR)); // R5
endmodule

// File: rtl/adc_irq_ctrl.sv
// ADC result-flag and interrupt-vector controller. Decodes the register
// port, detects the overwrite and conversion-time errors, raises irq from
// the registered vector and pulses the DMA trigger. Assumes single-cycle
// bus accesses and a slot count of 16 or fewer.
module adc_irq_ctrl #(
    parameter int SLOTS = 16,
    parameter int DW    = 12,
    parameter int AW    = 5,
    localparam int IW   = $clog2(SLOTS),
    localparam int BW   = adc_irq_pkg::BUS_W,
    localparam int VW   = $clog2(adc_irq_pkg::VEC_SLOT + 2 * SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          res_we,
    input  logic [IW-1:0] res_idx,
    input  logic [DW-1:0] res_data,
    input  logic          seq_mode,
    input  logic          seq_last,
    input  logic          conv_req,
    input  logic          conv_busy,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [BW-1:0] bus_wdata,
    output logic [BW-1:0] bus_rdata,
    output logic          irq,
    output logic          dma_trig
);
    import adc_irq_pkg::*;

    localparam logic [AW-1:0] A_FLAGS = AW'(SLOTS);
    localparam logic [AW-1:0] A_EN    = AW'(SLOTS + 1);
    localparam logic [AW-1:0] A_CTRL  = AW'(SLOTS + 2);
    localparam logic [AW-1:0] A_VEC   = AW'(SLOTS + 3);

    logic [SLOTS-1:0]         flags, slot_en;
    logic [SLOTS-1:0][DW-1:0] data;
    logic [2:0]               ctrl;
    logic [VW-1:0]            vec_q;
    logic                     ovr_pend, tov_pend, ovr_set, tov_set;
    logic                     is_slot, slot_rd, flag_ld, vec_acc;

    // decode bus accesses and error events
    always_comb begin
        is_slot = bus_addr < AW'(SLOTS);
        slot_rd = bus_sel && !bus_wr && is_slot;
        flag_ld = bus_sel && bus_wr && bus_addr == A_FLAGS;
        vec_acc = bus_sel && bus_addr == A_VEC;
        ovr_set = res_we && flags[res_idx];
        tov_set = conv_req && conv_busy;
    end

    // software-written enable and control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_en <= '0;
            ctrl    <= '0;
        end else if (bus_sel && bus_wr) begin
            if (bus_addr == A_EN)   slot_en <= bus_wdata[SLOTS-1:0];
            if (bus_addr == A_CTRL) ctrl    <= bus_wdata[2:0];
        end
    end

    // DMA trigger: every result in single mode, last result in sequence mode
    always_ff @(posedge clk) begin
        if (!rst_n) dma_trig <= 1'b0;
        else        dma_trig <= res_we && (!seq_mode || seq_last);
    end

    // read-data multiplexer
    always_comb begin
        bus_rdata = '0;
        if (is_slot)                 bus_rdata = BW'(data[bus_addr[IW-1:0]]);
        else if (bus_addr == A_FLAGS) bus_rdata = BW'(flags);
        else if (bus_addr == A_EN)    bus_rdata = BW'(slot_en);
        else if (bus_addr == A_CTRL)  bus_rdata = BW'(ctrl);
        else if (bus_addr == A_VEC)   bus_rdata = BW'(vec_q);
    end

    // interrupt request from the registered vector
    always_comb irq = ctrl[0] && (vec_q != '0);

    adc_slot_bank #(.SLOTS(SLOTS), .DW(DW)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(res_we), .wr_idx(res_idx), .wr_data(res_data),
        .rd_clr(slot_rd), .rd_idx(bus_addr[IW-1:0]),
        .sw_ld(flag_ld), .sw_val(bus_wdata[SLOTS-1:0]),
        .flags(flags), .data(data)
    );

    adc_err_flag u_ovr (
        .clk(clk), .rst_n(rst_n), .set_i(ovr_set),
        .clr_i(vec_acc && vec_q == VW'(VEC_OVR)), .pend_o(ovr_pend)
    );

    adc_err_flag u_tov (
        .clk(clk), .rst_n(rst_n), .set_i(tov_set),
        .clr_i(vec_acc && vec_q == VW'(VEC_TOV)), .pend_o(tov_pend)
    );

    adc_vec_prio #(.SLOTS(SLOTS), .VW(VW)) u_prio (
        .clk(clk), .rst_n(rst_n), .flags(flags), .slot_en(slot_en),
        .ovr_pend(ovr_pend), .ovr_en(ctrl[1]),
        .tov_pend(tov_pend), .tov_en(ctrl[2]), .vec_q(vec_q)
    );

    AST_OVR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we && flags[res_idx]) |=> ovr_pend); // R3
    AST_TOV_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && conv_busy) |=> tov_pend); // R4
    AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_acc && vec_q == VW'(VEC_OVR) && !ovr_set) |=> !ovr_pend); // R7
    AST_VEC_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        vec_acc |=> (flags & $past(flags)) == $past(flags)); // R8
    AST_DMA_MID_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we && seq_mode && !seq_last) |=> !dma_trig); // R9
endmodule

// File: tb/adc_irq_ctrl_test.sv
module adc_irq_ctrl_test;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        res_we = 0, seq_mode = 0, seq_last = 0, conv_req = 0, conv_busy = 0;
    logic [3:0]  res_idx = 0;
    logic [11:0] res_data = 0;
    logic        bus_sel = 0, bus_wr = 0;
    logic [4:0]  bus_addr = 0;
    logic [15:0] bus_wdata = 0, bus_rdata;
    logic        irq, dma_trig;
    int          n_run = 0, n_fail = 0;
    logic        done = 1'b0;

    localparam logic [4:0] A_FLAGS = 16, A_EN = 17, A_CTRL = 18, A_VEC = 19;

    always #2 clk = ~clk;

    adc_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .res_we(res_we), .res_idx(res_idx),
        .res_data(res_data), .seq_mode(seq_mode), .seq_last(seq_last),
        .conv_req(conv_req), .conv_busy(conv_busy), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .dma_trig(dma_trig)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // every task starts and ends at a falling edge
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [4:0] a, output int v);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 v = int'(bus_rdata);
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic res(input int idx, input int d, input logic sm, input logic sl);
        res_we = 1; res_idx = 4'(idx); res_data = 12'(d); seq_mode = sm; seq_last = sl;
        @(negedge clk);
        res_we = 0; seq_mode = 0; seq_last = 0;
    endtask

    task automatic conv(input logic busy);
        conv_req = 1; conv_busy = busy;
        @(negedge clk);
        conv_req = 0; conv_busy = 0;
    endtask

    task automatic t_reset;
        int v;
        chk("R1 irq", int'(irq), 0);
        chk("R1 dma", int'(dma_trig), 0);
        rd(A_VEC, v);   chk("R1 vector", v, 0);
        rd(A_FLAGS, v); chk("R1 flags", v, 0);
        rd(A_EN, v);    chk("R1 enables", v, 0);
    endtask

    task automatic t_slot;
        int v;
        wr(A_CTRL, 16'h7); wr(A_EN, 16'hFFFF); idle(1);
        res(3, 12'hABC, 0, 0);
        chk("R11 irq not yet", int'(irq), 0);
        idle(1);
        chk("R11 R6 irq after two clocks", int'(irq), 1);
        rd(A_VEC, v); chk("R5 slot3 code", v, 12);
        idle(1);
        rd(A_VEC, v); chk("R8 vector access keeps slot code", v, 12);
        rd(A_FLAGS, v); chk("R8 flag kept after vector access", v, 16'h0008);
        rd(5'd3, v); chk("R2 slot data", v, 12'hABC);
        rd(A_FLAGS, v); chk("R8 slot read clears flag", v, 0);
        rd(A_VEC, v); chk("R5 vector empty", v, 0);
        chk("R6 irq low", int'(irq), 0);
    endtask

    task automatic t_dma;
        int v;
        res(0, 1, 0, 0); chk("R9 single pulse", int'(dma_trig), 1);
        idle(1);         chk("R9 one cycle", int'(dma_trig), 0);
        res(1, 2, 1, 0); chk("R9 mid sequence", int'(dma_trig), 0);
        res(2, 3, 1, 1); chk("R9 last of sequence", int'(dma_trig), 1);
        wr(A_FLAGS, 16'h0); idle(1);
        rd(A_FLAGS, v); chk("R8 flag register load", v, 0);
    endtask

    task automatic t_ovr;
        int v;
        res(5, 1, 0, 0); res(5, 2, 0, 0); idle(1);
        rd(A_VEC, v); chk("R3 overwrite code", v, 2);
        idle(1);
        rd(A_VEC, v); chk("R7 overwrite cleared, slot5 next", v, 16);
        rd(5'd5, v); chk("R2 newer result kept", v, 2);
        idle(1);
    endtask

    task automatic t_tov;
        int v;
        conv(0); idle(1);
        rd(A_VEC, v); chk("R4 request while idle", v, 0);
        conv(1); idle(1);
        rd(A_VEC, v); chk("R4 request while busy", v, 4);
        wr(A_VEC, 16'h0); idle(1);
        rd(A_VEC, v); chk("R7 write access clears", v, 0);
    endtask

    task automatic t_both;
        int v;
        conv(1); res(7, 1, 0, 0); res(7, 2, 0, 0); idle(1);
        rd(A_VEC, v); chk("R5 overwrite above conv-time", v, 2);
        idle(1);
        rd(A_VEC, v); chk("R7 conv-time left pending", v, 4);
        idle(1);
        rd(A_VEC, v); chk("R5 slot7 after errors", v, 20);
        chk("R12 irq stays", int'(irq), 1);
        wr(A_FLAGS, 16'h0); idle(1);
    endtask

    task automatic t_not_top;
        int v;
        wr(A_CTRL, 16'h5);
        res(8, 1, 0, 0); res(8, 2, 0, 0); conv(1); idle(1);
        rd(A_VEC, v); chk("R5 disabled overwrite hidden", v, 4);
        idle(1);
        wr(A_CTRL, 16'h7); idle(1);
        rd(A_VEC, v); chk("R7 overwrite not cleared while hidden", v, 2);
        idle(1);
        rd(A_VEC, v); chk("R7 slot8 after overwrite", v, 22);
        wr(A_FLAGS, 16'h0); idle(1);
    endtask

    task automatic t_prio;
        int v;
        res(9, 1, 0, 0); res(2, 1, 0, 0); idle(1);
        rd(A_VEC, v); chk("R5 slot2 above slot9", v, 10);
        wr(A_EN, 16'hFFFB); idle(1);
        rd(A_VEC, v); chk("R5 disabled slot2 skipped", v, 24);
        wr(A_CTRL, 16'h6); idle(1);
        chk("R6 global enable off", int'(irq), 0);
        wr(A_CTRL, 16'h7); idle(1);
        chk("R6 global enable on", int'(irq), 1);
        wr(A_EN, 16'h0); idle(1);
        rd(A_VEC, v); chk("R5 all disabled", v, 0);
        wr(A_EN, 16'hFFFF); wr(A_FLAGS, 16'h0); idle(1);
    endtask

    task automatic t_setwins;
        int v;
        bus_sel = 1; bus_wr = 1; bus_addr = A_FLAGS; bus_wdata = 16'h0;
        res_we = 1; res_idx = 4; res_data = 12'h55;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; res_we = 0;
        rd(A_FLAGS, v); chk("R10 set beats load", v, 16'h0010);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset; t_slot; t_dma; t_ovr; t_tov; t_both; t_not_top; t_prio; t_setwins;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule